// File: doc/BRIEF.md
# Privileged instruction trap decider

This block decides, in a single combinational pass, what the core must do with five privileged instructions: wait-for-interrupt, wait-on-reservation-set without timeout, the supervisor address-translation fence, the hypervisor translation fence and the hypervisor guest-physical fence. It looks at the instruction class, the current privilege, whether the hart runs virtualized, whether supervisor mode exists, and four trap-control bits: timeout-wait and trap-virtual-memory from the machine status, and their virtualized counterparts from the hypervisor status.

The answer is one of four verdicts in one-hot form (execute, halt, illegal-instruction trap, virtual-instruction trap) plus a flush-request strobe that tells the translation cache to drop its entries. The core samples these in the same cycle it presents the instruction; the actual flush and the wake-up from halt live elsewhere.

Internally the decision is split into two rule engines. The wait engine has the named outcomes WAIT_HALT, WAIT_NOOP, WAIT_ILLEGAL and WAIT_VIRTUAL; the fence engine has FENCE_FLUSH, FENCE_ILLEGAL and FENCE_VIRTUAL. The top selects between them with a class decode (CLASS_WAIT_INT, CLASS_WAIT_RSV, CLASS_FENCE_SUP, CLASS_FENCE_HYP, CLASS_FENCE_GPA, CLASS_OTHER) and maps the chosen outcome onto the verdict encoding. There are no stored states and no transitions: every outcome depends only on the present inputs.

Top module: `priv_trap_decider`

## Requirements
- R1: The verdict output is one-hot with bit 0 execute, bit 1 halt, bit 2 illegal-instruction trap and bit 3 virtual-instruction trap; privilege is encoded 0 user, 1 supervisor, 3 machine.
- R2: For class 1 (wait-for-interrupt) the verdict is illegal when timeout-wait is set and privilege is supervisor, or timeout-wait is set and privilege is user with no supervisor mode, or privilege is user with supervisor mode present and virtualization off.
- R3: For class 1 when R2 does not apply, the verdict is virtual when virtualization is on and privilege is user, or virtualization is on, privilege is supervisor and the virtual timeout-wait bit is set; in every other case the verdict is halt.
- R4: For class 2 (wait-on-reservation-set) the verdict is virtual when virtualization is on, privilege is user or supervisor, the virtual timeout-wait bit is set and timeout-wait is clear.
- R5: For class 2 when R4 does not apply, the verdict is illegal when privilege is not machine and timeout-wait is set, and execute otherwise.
- R6: For class 3 (supervisor fence) the verdict is illegal when virtualization is off and privilege is user or supervisor with trap-virtual-memory set; else virtual when virtualization is on and privilege is user or the virtual trap-virtual-memory bit is set; else execute.
- R7: For class 4 (hypervisor fence) the verdict is virtual whenever virtualization is on; otherwise execute when privilege is machine or supervisor, and illegal for user.
- R8: For class 5 (guest-physical fence) the verdict is illegal for non-virtualized supervisor with trap-virtual-memory set; otherwise the R7 rules apply.
- R9: The flush strobe is high exactly when the verdict is execute and the class is 3, 4 or 5.
- R10: Classes 0, 6 and 7 give the execute verdict with the flush strobe low, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 3 | Instruction class code (1..5 decoded, others unknown) |
| priv_lvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Hart runs virtualized |
| smode_present | input | 1 | Supervisor mode is implemented |
| mst_tw | input | 1 | Machine status timeout-wait bit |
| mst_tvm | input | 1 | Machine status trap-virtual-memory bit |
| hst_vtw | input | 1 | Hypervisor status virtual timeout-wait bit |
| hst_vtvm | input | 1 | Hypervisor status virtual trap-virtual-memory bit |
| verdict | output | 4 | One-hot verdict: execute, halt, illegal, virtual |
| flush_req | output | 1 | Translation-cache flush request |

## Verification
The bench sweeps every class code against every legal privilege and every combination of the six flag inputs, one combination per clock, so each priority boundary is crossed from both sides. Sweeping timeout-wait against its virtual counterpart separates the two orderings of the wait instructions, where wait-for-interrupt tests illegal first and wait-on-reservation-set tests virtual first. Toggling supervisor presence in user mode distinguishes the two illegal paths of wait-for-interrupt, and sweeping trap-virtual-memory under the guest-physical class shows its extra illegal check ahead of the hypervisor fence rules. Unknown class codes under all flag patterns confirm the flags have no effect there.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
    localparam int CLASS_W   = 3;
    localparam int PRIV_W    = 2;
    localparam int VERDICT_N = 4;

    localparam logic [PRIV_W-1:0] PRIV_USER    = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_SUPER   = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;

    typedef enum logic [CLASS_W-1:0] {
        CLASS_OTHER     = 3'd0,
        CLASS_WAIT_INT  = 3'd1,
        CLASS_WAIT_RSV  = 3'd2,
        CLASS_FENCE_SUP = 3'd3,
        CLASS_FENCE_HYP = 3'd4,
        CLASS_FENCE_GPA = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        WAIT_HALT    = 2'd0,
        WAIT_NOOP    = 2'd1,
        WAIT_ILLEGAL = 2'd2,
        WAIT_VIRTUAL = 2'd3
    } wait_out_e;

    typedef enum logic [1:0] {
        FENCE_FLUSH   = 2'd0,
        FENCE_ILLEGAL = 2'd1,
        FENCE_VIRTUAL = 2'd2
    } fence_out_e;

    typedef enum logic [1:0] {
        FENCE_KIND_SUP = 2'd0,
        FENCE_KIND_HYP = 2'd1,
        FENCE_KIND_GPA = 2'd2
    } fence_kind_e;

    localparam int V_EXEC = 0;
    localparam int V_HALT = 1;
    localparam int V_ILL  = 2;
    localparam int V_VIRT = 3;
endpackage

// File: rtl/wait_rules.sv
module wait_rules
    import priv_trap_pkg::*;
(
    input  logic              is_rsv,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              virt_on,
    input  logic              smode_present,
    input  logic              mst_tw,
    input  logic              hst_vtw,
    output wait_out_e         outcome
);
    logic at_user;
    logic at_super;
    logic at_machine;

    always_comb begin
        at_user    = (priv_lvl == PRIV_USER);
        at_super   = (priv_lvl == PRIV_SUPER);
        at_machine = (priv_lvl == PRIV_MACHINE);
    end

    always_comb begin
        outcome = WAIT_HALT;
        if (is_rsv) begin
            // Virtual check ranks above the illegal check here.
            if (virt_on && (at_user || at_super) && hst_vtw && !mst_tw)
                outcome = WAIT_VIRTUAL;
            else if (!at_machine && mst_tw)
                outcome = WAIT_ILLEGAL;
            else
                outcome = WAIT_NOOP;
        end else begin
            // Illegal check ranks above the virtual check here.
            if (((at_super || (!smode_present && at_user)) && mst_tw) ||
                (smode_present && at_user && !virt_on))
                outcome = WAIT_ILLEGAL;
            else if (virt_on && (at_user || (at_super && hst_vtw)))
                outcome = WAIT_VIRTUAL;
            else
                outcome = WAIT_HALT;
        end
    end

    always_comb begin
        if (!is_rsv && at_machine && !virt_on)
            assert_wfi_machine_halts_R3: assert (outcome == WAIT_HALT)
                else $error("machine-mode wait did not halt");
        if (is_rsv && !mst_tw && !virt_on)
            assert_rsv_free_noop_R5: assert (outcome == WAIT_NOOP)
                else $error("unrestricted reservation wait trapped");
    end
endmodule

// File: rtl/fence_rules.sv
module fence_rules
    import priv_trap_pkg::*;
(
    input  fence_kind_e       kind,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              virt_on,
    input  logic              mst_tvm,
    input  logic              hst_vtvm,
    output fence_out_e        outcome
);
    logic at_user;
    logic at_super;
    logic at_machine;
    fence_out_e hyp_out;

    always_comb begin
        at_user    = (priv_lvl == PRIV_USER);
        at_super   = (priv_lvl == PRIV_SUPER);
        at_machine = (priv_lvl == PRIV_MACHINE);
    end

    // Hypervisor fence rules, shared by the guest-physical variant.
    always_comb begin
        if (virt_on)
            hyp_out = FENCE_VIRTUAL;
        else if (at_machine || at_super)
            hyp_out = FENCE_FLUSH;
        else
            hyp_out = FENCE_ILLEGAL;
    end

    always_comb begin
        outcome = FENCE_FLUSH;
        unique case (kind)
            FENCE_KIND_SUP: begin
                if (!virt_on && (at_user || (at_super && mst_tvm)))
                    outcome = FENCE_ILLEGAL;
                else if (virt_on && (at_user || hst_vtvm))
                    outcome = FENCE_VIRTUAL;
                else
                    outcome = FENCE_FLUSH;
            end
            FENCE_KIND_HYP: outcome = hyp_out;
            FENCE_KIND_GPA: begin
                if (at_super && !virt_on && mst_tvm)
                    outcome = FENCE_ILLEGAL;
                else
                    outcome = hyp_out;
            end
            default: outcome = FENCE_FLUSH;
        endcase
    end

    always_comb begin
        if (virt_on && at_user)
            assert_virt_user_fence_traps_R6: assert (outcome == FENCE_VIRTUAL)
                else $error("virtualized user fence not trapped");
        if (kind == FENCE_KIND_HYP && at_user && !virt_on)
            assert_hyp_user_illegal_R7: assert (outcome == FENCE_ILLEGAL)
                else $error("user hypervisor fence not illegal");
    end
endmodule

// File: rtl/priv_trap_decider.sv
module priv_trap_decider
    import priv_trap_pkg::*;
(
    input  logic [2:0] op_class,
    input  logic [1:0] priv_lvl,
    input  logic       virt_on,
    input  logic       smode_present,
    input  logic       mst_tw,
    input  logic       mst_tvm,
    input  logic       hst_vtw,
    input  logic       hst_vtvm,
    output logic [3:0] verdict,
    output logic       flush_req
);
    op_class_e   cls;
    wait_out_e   wait_out;
    fence_out_e  fence_out;
    fence_kind_e fkind;
    logic        is_rsv;

    always_comb begin
        cls = op_class_e'(op_class);
        is_rsv = (cls == CLASS_WAIT_RSV);
        unique case (cls)
            CLASS_FENCE_HYP: fkind = FENCE_KIND_HYP;
            CLASS_FENCE_GPA: fkind = FENCE_KIND_GPA;
            default:         fkind = FENCE_KIND_SUP;
        endcase
    end

    wait_rules u_wait (
        .is_rsv        (is_rsv),
        .priv_lvl      (priv_lvl),
        .virt_on       (virt_on),
        .smode_present (smode_present),
        .mst_tw        (mst_tw),
        .hst_vtw       (hst_vtw),
        .outcome       (wait_out)
    );

    fence_rules u_fence (
        .kind     (fkind),
        .priv_lvl (priv_lvl),
        .virt_on  (virt_on),
        .mst_tvm  (mst_tvm),
        .hst_vtvm (hst_vtvm),
        .outcome  (fence_out)
    );

    always_comb begin
        verdict   = '0;
        flush_req = 1'b0;
        unique case (cls)
            CLASS_WAIT_INT, CLASS_WAIT_RSV: begin
                unique case (wait_out)
                    WAIT_HALT:    verdict[V_HALT] = 1'b1;
                    WAIT_NOOP:    verdict[V_EXEC] = 1'b1;
                    WAIT_ILLEGAL: verdict[V_ILL]  = 1'b1;
                    WAIT_VIRTUAL: verdict[V_VIRT] = 1'b1;
                    default:      verdict[V_EXEC] = 1'b1;
                endcase
            end
            CLASS_FENCE_SUP, CLASS_FENCE_HYP, CLASS_FENCE_GPA: begin
                unique case (fence_out)
                    FENCE_FLUSH: begin
                        verdict[V_EXEC] = 1'b1;
                        flush_req       = 1'b1;
                    end
                    FENCE_ILLEGAL: verdict[V_ILL]  = 1'b1;
                    FENCE_VIRTUAL: verdict[V_VIRT] = 1'b1;
                    default:       verdict[V_ILL]  = 1'b1;
                endcase
            end
            default: verdict[V_EXEC] = 1'b1;
        endcase
    end

    always_comb begin
        assert_verdict_onehot_R1: assert ($onehot(verdict))
            else $error("verdict not one-hot");
        if (flush_req)
            assert_flush_needs_exec_R9: assert (verdict[V_EXEC])
                else $error("flush without execute verdict");
        if (virt_on && (cls == CLASS_FENCE_HYP || cls == CLASS_FENCE_GPA))
            assert_virt_hyp_fence_R8: assert (verdict[V_VIRT])
                else $error("virtualized hypervisor fence not virtual trap");
        if (op_class == 3'd0 || op_class >= 3'd6)
            assert_unknown_exec_R10: assert (verdict[V_EXEC] && !flush_req)
                else $error("unknown class not executed cleanly");
    end
endmodule

// File: tb/priv_trap_decider_tb.sv
module priv_trap_decider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic [2:0] op_class = '0;
    logic [1:0] priv_lvl = '0;
    logic       virt_on = 1'b0, smode_present = 1'b0;
    logic       mst_tw = 1'b0, mst_tvm = 1'b0, hst_vtw = 1'b0, hst_vtvm = 1'b0;
    logic [3:0] verdict;
    logic       flush_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    priv_trap_decider dut_i (
        .op_class(op_class), .priv_lvl(priv_lvl), .virt_on(virt_on),
        .smode_present(smode_present), .mst_tw(mst_tw), .mst_tvm(mst_tvm),
        .hst_vtw(hst_vtw), .hst_vtvm(hst_vtvm),
        .verdict(verdict), .flush_req(flush_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 exec, 1 halt, 2 illegal, 3 virtual.
    function automatic int ref_kind(input int c, input int p, input bit v,
                                    input bit s, input bit tw, input bit tvm,
                                    input bit vtw, input bit vtvm);
        bit u = (p == 0), su = (p == 1), m = (p == 3);
        case (c)
            1: begin // R2 then R3
                if ((su && tw) || (u && !s && tw) || (u && s && !v)) return 2;
                if (v && u) return 3;
                if (v && su && vtw) return 3;
                return 1;
            end
            2: begin // R4 then R5
                if (v && !m && vtw && !tw) return 3;
                if (!m && tw) return 2;
                return 0;
            end
            3: begin // R6
                if (!v && u) return 2;
                if (!v && su && tvm) return 2;
                if (v && (u || vtvm)) return 3;
                return 0;
            end
            4, 5: begin // R7, R8
                if (c == 5 && su && !v && tvm) return 2;
                if (v) return 3;
                if (m || su) return 0;
                return 2;
            end
            default: return 0; // R10
        endcase
    endfunction

    function automatic string req_of(input int c, input int k);
        case (c)
            1: return (k == 2) ? "R2" : "R3";
            2: return (k == 3) ? "R4" : "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check_now(input int c, input int p, input bit v, input bit s,
                             input bit tw, input bit tvm, input bit vtw, input bit vtvm);
        int k = ref_kind(c, p, v, s, tw, tvm, vtw, vtvm);
        logic [3:0] exp_v = 4'b0001 << k;
        bit exp_f = (k == 0) && (c >= 3 && c <= 5);
        total++;
        if (verdict !== exp_v) begin
            bad++;
            $display("FAIL %s/R1 class=%0d priv=%0d v=%0b s=%0b tw=%0b tvm=%0b vtw=%0b vtvm=%0b verdict actual=%b expected=%b",
                     req_of(c, k), c, p, v, s, tw, tvm, vtw, vtvm, verdict, exp_v);
        end
        total++;
        if (flush_req !== exp_f) begin
            bad++;
            $display("FAIL R9 class=%0d priv=%0d v=%0b flush actual=%b expected=%b",
                     c, p, v, flush_req, exp_f);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset-like idle state: all inputs zero, class 0 -> execute, no flush (R10).
        @(negedge clk);
        check_now(0, 0, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < 8; c++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int f = 0; f < 64; f++) begin
                    @(posedge clk);
                    #1;
                    op_class      = 3'(c);
                    priv_lvl      = (pi == 2) ? 2'd3 : 2'(pi);
                    virt_on       = f[0];
                    smode_present = f[1];
                    mst_tw        = f[2];
                    mst_tvm       = f[3];
                    hst_vtw       = f[4];
                    hst_vtvm      = f[5];
                    @(negedge clk);
                    check_now(c, int'(priv_lvl), f[0], f[1], f[2], f[3], f[4], f[5]);
                end
            end
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule